// File: doc/BRIEF.md
# Multi-channel electronic breaker controller

This block drives the enable lines of a ten-channel DC power distribution board. It acts as a set of resettable electronic circuit breakers. Each channel takes a synchronous on/off request from a control register and an asynchronous overcurrent flag from an external comparator. It drives one switch-enable output. When a channel is switched on, its overcurrent flag is masked for a programmable number of clock cycles so that inrush current does not trip it. After that window, an overcurrent turns the channel off and latches it in an error state. The error state clears only when the request is dropped and raised again.

Three board-level fault inputs (over-temperature, undervoltage and overvoltage) shut every live channel down into the same latched error state. Each affected channel must then be re-cycled once the fault is gone. Every channel's state is reported as a two-bit code so that control software can power-cycle boards and see which ones have tripped.

Top module: `breaker_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge with `rst` high, every `drive_en` bit is 0 and every channel status reads OFF. This holds whatever the request inputs are.
- R2: A channel in OFF whose request is high, with no global fault, enters INRUSH on the next edge with its `drive_en` high. It reads INRUSH for exactly `blank_cycles`+1 cycles and then reads ON.
- R3: The overcurrent input of a channel in INRUSH is ignored: the channel stays in INRUSH and keeps driving.
- R4: An overcurrent input raised on a channel in ON turns its `drive_en` off and sets ERROR on the third rising edge after the input is raised. Two of those edges are for synchronization and one is for the trip.
- R5: A channel in ERROR keeps `drive_en` low and stays in ERROR for as long as its request stays high, even after the overcurrent or fault has gone.
- R6: A channel in ERROR whose request is low returns to OFF on the next edge. A later request starts a fresh INRUSH window.
- R7: Dropping the request of a channel in INRUSH or ON turns it OFF on the next edge.
- R8: Any of the three fault inputs moves every channel in INRUSH or ON to ERROR on the fourth rising edge after the input is raised. Channels in OFF stay OFF while the fault is present, and may start only on the fourth edge after it clears.
- R9: `blank_cycles` is sampled only when a channel leaves OFF. Changing it during a channel's INRUSH does not alter that channel's window.
- R10: Channels are independent: the request and overcurrent of one channel never change another channel's drive or status.
- R11: Status bits [2i+1:2i] give channel i's state, encoded as OFF=0, INRUSH=1, ON=2, ERROR=3. `drive_en` bit i is high exactly in INRUSH and ON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| on_req | input | NCH | Per-channel on request, synchronous to `clk` |
| oc_in | input | NCH | Per-channel overcurrent flag, asynchronous, active high |
| flt_temp | input | 1 | Over-temperature fault, asynchronous, active high |
| flt_uv | input | 1 | Undervoltage fault, asynchronous, active high |
| flt_ov | input | 1 | Overvoltage fault, asynchronous, active high |
| blank_cycles | input | CNT_W | Inrush blanking length, in clock cycles |
| drive_en | output | NCH | Registered power-switch enables |
| status | output | 2*NCH | Registered channel states, two bits per channel |

## Verification
A request change shows on `drive_en` and `status` one edge later. An overcurrent shows three edges later, and a global fault four edges later because of the extra merge register. The ON state appears `blank_cycles`+2 edges after the request. The bench changes inputs only on falling edges. It then waits the exact number of falling edges its table or directed step prescribes before sampling. Some checks sit one edge before each deadline, to confirm that nothing changes early.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    CH_OFF    = 2'd0,
    CH_INRUSH = 2'd1,
    CH_ON     = 2'd2,
    CH_ERROR  = 2'd3
  } ch_state_e;
endpackage

// File: rtl/brk_sync.sv
module brk_sync #(
  parameter int WIDTH  = 13,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/brk_fault_merge.sv
module brk_fault_merge #(
  parameter int NFLT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NFLT-1:0] flt_s,
  output logic            fault_any
);
  // One register after the OR keeps the fan-out to all channels short.
  always_ff @(posedge clk) begin
    if (rst) fault_any <= 1'b0;
    else     fault_any <= |flt_s;
  end
endmodule

// File: rtl/brk_channel.sv
module brk_channel
  import brk_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on_req,
  input  logic             oc_s,
  input  logic             fault,
  input  logic [CNT_W-1:0] blank,
  output logic             drive_en,
  output ch_state_e        state
);
  ch_state_e        nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt = state;
    unique case (state)
      CH_OFF:    if (on_req && !fault) nxt = CH_INRUSH;
      CH_INRUSH: begin
        if (fault)             nxt = CH_ERROR;
        else if (!on_req)      nxt = CH_OFF;
        else if (cnt == '0)    nxt = CH_ON;
      end
      CH_ON: begin
        if (fault || oc_s)     nxt = CH_ERROR;
        else if (!on_req)      nxt = CH_OFF;
      end
      CH_ERROR:  if (!on_req) nxt = CH_OFF;
      default:   nxt = CH_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CH_OFF;
      drive_en <= 1'b0;
      cnt      <= '0;
    end else begin
      state    <= nxt;
      drive_en <= (nxt == CH_INRUSH) || (nxt == CH_ON);
      if (state == CH_OFF)                      cnt <= blank;
      else if (state == CH_INRUSH && cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  AST_INRUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == CH_INRUSH && on_req && !fault && cnt != '0) |=> (state == CH_INRUSH && drive_en)); // R3
  AST_OC_TRIP: assert property (@(posedge clk) disable iff (rst)
    (state == CH_ON && oc_s) |=> (state == CH_ERROR && !drive_en)); // R4
  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (rst)
    (state == CH_ERROR && on_req) |=> (state == CH_ERROR && !drive_en)); // R5
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (state == CH_ERROR && !on_req) |=> (state == CH_OFF)); // R6
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    ((state == CH_ON || state == CH_INRUSH) && !on_req && !fault && !oc_s) |=> (state == CH_OFF && !drive_en)); // R7
  AST_FAULT_KILL: assert property (@(posedge clk) disable iff (rst)
    (fault && (state == CH_ON || state == CH_INRUSH)) |=> (state == CH_ERROR)); // R8
  AST_FAULT_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    (fault && state == CH_OFF) |=> (state == CH_OFF && !drive_en)); // R8
endmodule

// File: rtl/breaker_ctrl.sv
module breaker_ctrl
  import brk_pkg::*;
#(
  parameter int NCH   = 10,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   on_req,
  input  logic [NCH-1:0]   oc_in,
  input  logic             flt_temp,
  input  logic             flt_uv,
  input  logic             flt_ov,
  input  logic [CNT_W-1:0] blank_cycles,
  output logic [NCH-1:0]   drive_en,
  output logic [2*NCH-1:0] status
);
  localparam int NFLT  = 3;
  localparam int SYNCW = NCH + NFLT;

  logic [SYNCW-1:0] sync_q;
  logic [NCH-1:0]   oc_s;
  logic [NFLT-1:0]  flt_s;
  logic             fault_any;

  brk_sync #(.WIDTH(SYNCW), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({flt_ov, flt_uv, flt_temp, oc_in}),
    .q_sync  (sync_q)
  );

  assign oc_s  = sync_q[NCH-1:0];
  assign flt_s = sync_q[SYNCW-1:NCH];

  brk_fault_merge #(.NFLT(NFLT)) u_fault (
    .clk       (clk),
    .rst       (rst),
    .flt_s     (flt_s),
    .fault_any (fault_any)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ch_state_e st;
    brk_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .on_req   (on_req[i]),
      .oc_s     (oc_s[i]),
      .fault    (fault_any),
      .blank    (blank_cycles),
      .drive_en (drive_en[i]),
      .state    (st)
    );
    assign status[2*i +: 2] = st;

    AST_DRIVE_CODE: assert property (@(posedge clk) disable iff (rst)
      drive_en[i] == (status[2*i +: 2] == 2'd1 || status[2*i +: 2] == 2'd2)); // R11
  end
endmodule

// File: tb/sim_breaker_ctrl.sv
module sim_breaker_ctrl;
  localparam int NCH   = 10;
  localparam int CNT_W = 24;

  logic             clk = 1'b0;
  logic             rst;
  logic [NCH-1:0]   on_req;
  logic [NCH-1:0]   oc_in;
  logic             flt_temp, flt_uv, flt_ov;
  logic [CNT_W-1:0] blank_cycles;
  logic [NCH-1:0]   drive_en;
  logic [2*NCH-1:0] status;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  breaker_ctrl #(.NCH(NCH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .on_req(on_req), .oc_in(oc_in),
    .flt_temp(flt_temp), .flt_uv(flt_uv), .flt_ov(flt_ov),
    .blank_cycles(blank_cycles), .drive_en(drive_en), .status(status)
  );

  typedef struct packed {
    logic [9:0]  on;
    logic [9:0]  oc;
    logic [2:0]  flt;   // {ov, uv, temp}
    logic [3:0]  wt;    // falling edges to wait before sampling
    logic [9:0]  drv;
    logic [19:0] st;
  } vec_t;

  // Blanking is 3 cycles for the whole table.
  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{10'h003, 10'h000, 3'b000, 4'd1, 10'h003, 20'h00005}, // R2 enter INRUSH
    '{10'h003, 10'h001, 3'b000, 4'd3, 10'h003, 20'h00005}, // R3 oc masked
    '{10'h003, 10'h001, 3'b000, 4'd1, 10'h003, 20'h0000A}, // R2 ON after blank+1
    '{10'h003, 10'h001, 3'b000, 4'd1, 10'h002, 20'h0000B}, // R4 trip ch0
    '{10'h003, 10'h000, 3'b000, 4'd5, 10'h002, 20'h0000B}, // R5 latched
    '{10'h002, 10'h000, 3'b000, 4'd1, 10'h002, 20'h00008}, // R6 clear
    '{10'h003, 10'h000, 3'b000, 4'd1, 10'h003, 20'h00009}, // R6 fresh inrush
    '{10'h001, 10'h000, 3'b000, 4'd1, 10'h001, 20'h00001}, // R7 drop from ON
    '{10'h000, 10'h000, 3'b000, 4'd1, 10'h000, 20'h00000}, // R7 drop from INRUSH
    '{10'h004, 10'h000, 3'b000, 4'd1, 10'h004, 20'h00010}, // R10 ch2 alone
    '{10'h004, 10'h000, 3'b001, 4'd4, 10'h000, 20'h00030}, // R8 temp fault
    '{10'h00C, 10'h000, 3'b001, 4'd2, 10'h000, 20'h00030}, // R8 OFF held
    '{10'h008, 10'h000, 3'b000, 4'd1, 10'h000, 20'h00000}, // R8 fault still in pipe
    '{10'h008, 10'h000, 3'b000, 4'd4, 10'h008, 20'h00040}, // R8 start after clear
    '{10'h000, 10'h000, 3'b000, 4'd1, 10'h000, 20'h00000}, // R7
    '{10'h200, 10'h1FF, 3'b000, 4'd1, 10'h200, 20'h40000}, // R10 ch9
    '{10'h200, 10'h1FF, 3'b000, 4'd4, 10'h200, 20'h80000}, // R10 others' oc
    '{10'h000, 10'h000, 3'b000, 4'd1, 10'h000, 20'h00000}  // R11 all OFF
  };

  task automatic check(input string req, input logic [NCH-1:0] exp_drv,
                       input logic [2*NCH-1:0] exp_st);
    checks++;
    if (drive_en !== exp_drv || status !== exp_st) begin
      errors++;
      $display("FAIL %s: drive=%h status=%h expected drive=%h status=%h",
               req, drive_en, status, exp_drv, exp_st);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; on_req = '1; oc_in = '0;
    flt_temp = 1'b0; flt_uv = 1'b0; flt_ov = 1'b0;
    blank_cycles = 24'd3;
    waitn(1);
    check("R1 first edge in reset", '0, '0);
    waitn(3);
    check("R1 held in reset", '0, '0);
    on_req = '0;
    waitn(1);
    rst = 1'b0;
    waitn(2);
    check("R1 after release", '0, '0);

    for (int i = 0; i < NV; i++) begin
      on_req   = TBL[i].on;
      oc_in    = TBL[i].oc;
      {flt_ov, flt_uv, flt_temp} = TBL[i].flt;
      waitn(int'(TBL[i].wt));
      check($sformatf("R2/R3/R4/R5/R6/R7/R8/R10/R11 vector %0d", i), TBL[i].drv, TBL[i].st);
    end
    oc_in = '0;
    waitn(4);

    // R4 latency with zero blanking on channel 5
    blank_cycles = 24'd0;
    on_req = 10'h020;
    waitn(2);
    check("R4 ch5 ON", 10'h020, 20'h00800);
    oc_in = 10'h020;
    waitn(2);
    check("R4 no early trip", 10'h020, 20'h00800);
    waitn(1);
    check("R4 trip on third edge", 10'h000, 20'h00C00);
    oc_in = '0; on_req = '0;
    waitn(1);
    check("R6 back to OFF", '0, '0);

    // R9 window fixed at turn-on on channel 6
    blank_cycles = 24'd10;
    on_req = 10'h040;
    waitn(1);
    check("R9 inrush start", 10'h040, 20'h01000);
    blank_cycles = 24'd0;
    waitn(10);
    check("R9 still inrush after 11", 10'h040, 20'h01000);
    waitn(1);
    check("R9 ON after 12", 10'h040, 20'h02000);
    on_req = '0;
    waitn(2);

    // R8 undervoltage, all channels live
    on_req = '1;
    waitn(3);
    check("R8 all ON", 10'h3FF, 20'hAAAAA);
    flt_uv = 1'b1;
    waitn(3);
    check("R8 uv not yet", 10'h3FF, 20'hAAAAA);
    waitn(1);
    check("R8 uv trip all", 10'h000, 20'hFFFFF);
    flt_uv = 1'b0;
    waitn(5);
    check("R5 stays ERROR after fault", 10'h000, 20'hFFFFF);
    on_req = '0;
    waitn(1);
    check("R6 all clear", '0, '0);

    // R8 overvoltage
    on_req = 10'h101;
    waitn(3);
    flt_ov = 1'b1;
    waitn(4);
    check("R8 ov trip", 10'h000, 20'h30003);
    flt_ov = 1'b0; on_req = '0;
    waitn(5);

    // R1 reset while running
    on_req = '1;
    waitn(3);
    rst = 1'b1;
    waitn(1);
    check("R1 reset kills live channels", '0, '0);
    rst = 1'b0; on_req = '0;
    waitn(2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule